// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block is the device-side half of message-signalled interrupts with per-vector tables. Software programs a table through a 32-bit memory-mapped register port. Each vector has a 64-bit message address, a 32-bit message data word and a control word whose bit 0 masks the vector. Device logic raises interrupt requests by vector index. Each request is checked against the configured entry count and against a per-vector use counter that software maintains. A request that passes is sent as a single write message on a valid/ready port. If it cannot go out at once, it is parked in a pending-bit array.

A masked vector's request stays pending until a table write leaves that vector unmasked, and it is then replayed with no further action from software. Requests that arrive while a message is waiting for acceptance are also parked. They leave the pending array lowest vector first as the port frees up. The block also presents the capability flags word, which carries the read-only table-size field and a writable enable bit. It pulses a legacy-interrupt deassert strobe when a configuration write sets the enable bit.

Top module: `msix_vec_ctrl`

## Requirements
- R1: The table page uses byte addresses `reg_addr[11:0]`. Addresses below 0x800 hold the table, with entry `addr>>4` and word `(addr>>2)&3`. Word 0 is the address low word, word 1 the address high word, word 2 the data word and word 3 the control word. A word read (`reg_size`=2) returns the stored value in `reg_rdata` on the clock edge after the read request.
- R2: Byte (`reg_size`=0) and halfword (`reg_size`=1) reads return 0, and writes of those sizes are discarded. Table words of entries at or beyond `ENTRIES` read 0 and ignore writes.
- R3: A request (`irq_valid`, `irq_idx`) is dropped with no message and no pending bit when `irq_idx` >= `ENTRIES` or when that vector's use count is zero.
- R4: An accepted request to an unmasked vector, made while the message port is idle, raises `msg_valid` on the second clock edge after the request edge. The message carries `msg_addr` = {high word, low word} and `msg_data` = the data word of that entry.
- R5: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. `msg_valid` falls on the edge where `msg_ready` is sampled high.
- R6: An accepted request to a vector whose control bit 0 is 1 sends no message. It sets pending bit v, which is bit v of the word read at byte address 0x800 (bit v mod 8 of byte v/8).
- R7: When a table write leaves a pending vector unmasked, that pending bit clears and the vector's message is sent. A write that keeps the vector masked sends nothing.
- R8: Requests accepted while a message is outstanding become pending. Queued unmasked vectors are issued in ascending vector order, one after each handshake.
- R9: A use command (`vuse_valid`, `vuse_unuse`=0) increments that vector's counter, saturating at all-ones. For an index >= `ENTRIES` it instead pulses `vuse_err` for one cycle after the command edge. An unuse command (`vuse_unuse`=1) decrements the counter only when it is nonzero.
- R10: `cfg_flags[10:0]` reads `ENTRIES-1` and `cfg_flags[15]` is the enable bit. Only a configuration write with `cfg_be[1]`=1 changes the enable bit, which takes `cfg_wdata[15]`. All other flag bits are constant.
- R11: A configuration write with `cfg_be[1]`=1 and `cfg_wdata[15]`=1 raises `intx_clr` for the cycle after the write edge.
- R12: Reset clears every table word, all pending bits, all use counters, the enable bit, `msg_valid` and `intx_clr`.
- R13: The pending array is read-only, and writes to addresses at or above 0x800 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reg_addr | input | 12 | Byte address within the 4 KB page |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| cfg_wr | input | 1 | Capability flags write strobe |
| cfg_be | input | 2 | Byte lanes of the flags word |
| cfg_wdata | input | 16 | Flags write data |
| cfg_flags | output | 16 | Capability flags word |
| intx_clr | output | 1 | Legacy interrupt deassert pulse |
| vuse_valid | input | 1 | Use/unuse command strobe |
| vuse_unuse | input | 1 | 0 = use, 1 = unuse |
| vuse_idx | input | 5 | Vector of the command |
| vuse_err | output | 1 | Out-of-range use pulse |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_idx | input | 5 | Requested vector |
| msg_valid | output | 1 | Message pending on port |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench sweeps all eight vectors of the default configuration with computed table contents. It goes after the replay path: with every vector masked and pending, each unmask must release exactly one message. A design that replayed on any write, or cleared pending bits on mask changes, would emit the wrong vector or lose one. Queued requests made behind a stalled port must come out lowest vector first, which exposes first-come or highest-first selection. The unuse-at-zero case catches a counter that wraps to its maximum and so keeps delivering after software released the vector. Narrow accesses, out-of-range entries and writes to the pending region must leave read-back values untouched.

// File: rtl/msix_pkg.sv
package msix_pkg;
   localparam int MAX_VEC   = 32;
   localparam int VEC_IW    = 5;
   localparam int PAGE_AW   = 12;
   localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/msix_table.sv
module msix_table
   import msix_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int EW      = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_valid,
   input  logic                reg_write,
   input  logic [1:0]          reg_size,
   input  logic [PAGE_AW-1:0]  reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [ENTRIES-1:0]  pend,
   output logic [ENTRIES-1:0]  mask,
   input  logic [EW-1:0]       rd_idx,
   output logic [63:0]         rd_addr,
   output logic [31:0]         rd_data
);
   localparam int HALF_BIT = PAGE_AW - 1;

   logic [31:0] tbl [ENTRIES][4];
   logic [6:0]  ent;
   logic [1:0]  wsel;
   logic        in_tbl;
   logic        word_acc;
   logic [31:0] pba_word;
   logic [31:0] rd_word;

   assign ent      = reg_addr[10:4];
   assign wsel     = reg_addr[3:2];
   assign in_tbl   = !reg_addr[HALF_BIT] && (int'(ent) < ENTRIES);
   assign word_acc = (reg_size == SZ_WORD);

   generate
      if (ENTRIES == MAX_VEC) begin : g_pba_full
         assign pba_word = pend;
      end else begin : g_pba_pad
         assign pba_word = {{(MAX_VEC-ENTRIES){1'b0}}, pend};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++)
            for (int w = 0; w < 4; w++)
               tbl[e][w] <= '0;
      end else if (reg_valid && reg_write && word_acc && in_tbl) begin
         tbl[ent[EW-1:0]][wsel] <= reg_wdata;
      end
   end

   always_comb begin
      rd_word = '0;
      if (reg_addr[HALF_BIT]) begin
         if (reg_addr[10:2] == '0) rd_word = pba_word;
      end else if (in_tbl) begin
         rd_word = tbl[ent[EW-1:0]][wsel];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      reg_rdata <= '0;
      else if (reg_valid && !reg_write) reg_rdata <= word_acc ? rd_word : '0;
   end

   generate
      for (genvar v = 0; v < ENTRIES; v++) begin : g_mask
         assign mask[v] = tbl[v][3][0];
      end
   endgenerate

   assign rd_addr = {tbl[rd_idx][1], tbl[rd_idx][0]};
   assign rd_data = tbl[rd_idx][2];

   // R2: narrow reads return zero
   a_r2_narrow_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_write && !word_acc) |=> (reg_rdata == '0));
endmodule

// File: rtl/msix_use_cnt.sv
module msix_use_cnt
   import msix_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_unuse,
   input  logic [VEC_IW-1:0] cmd_idx,
   output logic [ENTRIES-1:0] inuse,
   output logic              use_err
);
   generate
      for (genvar v = 0; v < ENTRIES; v++) begin : g_cnt
         logic [CNT_W-1:0] cnt;
         logic             hit;
         assign hit = cmd_valid && (cmd_idx == VEC_IW'(v));
         always_ff @(posedge clk) begin
            if (!rst_n)                              cnt <= '0;
            else if (hit && !cmd_unuse && cnt != '1) cnt <= cnt + 1'b1;
            else if (hit && cmd_unuse && cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign inuse[v] = (cnt != '0);

         // R9: counter moves by at most one step per cycle
         a_r9_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) ||
                      (cnt == $past(cnt) - 1'b1)));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) use_err <= 1'b0;
      else        use_err <= cmd_valid && !cmd_unuse && (int'(cmd_idx) >= ENTRIES);
   end
endmodule

// File: rtl/msix_dispatch.sv
module msix_dispatch #(
   parameter int ENTRIES = 8,
   parameter int EW      = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] set_vec,
   input  logic [ENTRIES-1:0] mask,
   output logic [ENTRIES-1:0] pend,
   output logic [EW-1:0]      sel_idx,
   input  logic [63:0]        sel_addr,
   input  logic [31:0]        sel_data,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   logic [ENTRIES-1:0] cand;
   logic [ENTRIES-1:0] clr;
   logic               found;
   logic               launch;

   assign cand = pend & ~mask;

   always_comb begin
      found   = 1'b0;
      sel_idx = '0;
      for (int v = ENTRIES - 1; v >= 0; v--) begin
         if (cand[v]) begin
            found   = 1'b1;
            sel_idx = EW'(v);
         end
      end
   end

   assign launch = found && !msg_valid;

   always_comb begin
      clr = '0;
      if (launch) clr[sel_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= '0;
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else begin
         pend <= (pend & ~clr) | set_vec;
         if (launch) begin
            msg_valid <= 1'b1;
            msg_addr  <= sel_addr;
            msg_data  <= sel_data;
         end else if (msg_ready) begin
            msg_valid <= 1'b0;
         end
      end
   end

   // R5: message holds until accepted
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=>
         (msg_valid && $stable(msg_addr) && $stable(msg_data)));
   // R8: a launch needs an unmasked pending vector
   a_r8_launch_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past(|(pend & ~mask)));
   // R3: a pending bit only rises from an accepted request
   a_r3_pend_only_from_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
   import msix_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [1:0]        reg_size,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_be,
   input  logic [15:0]       cfg_wdata,
   output logic [15:0]       cfg_flags,
   output logic              intx_clr,
   input  logic              vuse_valid,
   input  logic              vuse_unuse,
   input  logic [4:0]        vuse_idx,
   output logic              vuse_err,
   input  logic              irq_valid,
   input  logic [4:0]        irq_idx,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [63:0]       msg_addr,
   output logic [31:0]       msg_data
);
   localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 1 || ENTRIES > MAX_VEC) begin : g_bad_entries
         $error("ENTRIES must be 1..32");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [ENTRIES-1:0] inuse;
   logic [ENTRIES-1:0] set_vec;
   logic [ENTRIES-1:0] mask;
   logic [ENTRIES-1:0] pend;
   logic [EW-1:0]      sel_idx;
   logic [63:0]        sel_addr;
   logic [31:0]        sel_data;
   logic               en;

   generate
      for (genvar v = 0; v < ENTRIES; v++) begin : g_accept
         assign set_vec[v] = irq_valid && (irq_idx == VEC_IW'(v)) && inuse[v];
      end
   endgenerate

   msix_table #(.ENTRIES(ENTRIES), .EW(EW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_size(reg_size),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pend(pend), .mask(mask),
      .rd_idx(sel_idx), .rd_addr(sel_addr), .rd_data(sel_data)
   );

   msix_use_cnt #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_use (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(vuse_valid), .cmd_unuse(vuse_unuse), .cmd_idx(vuse_idx),
      .inuse(inuse), .use_err(vuse_err)
   );

   msix_dispatch #(.ENTRIES(ENTRIES), .EW(EW)) u_disp (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec), .mask(mask), .pend(pend),
      .sel_idx(sel_idx), .sel_addr(sel_addr), .sel_data(sel_data),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= 1'b0;
         intx_clr <= 1'b0;
      end else begin
         if (cfg_wr && cfg_be[1]) en <= cfg_wdata[15];
         intx_clr <= cfg_wr && cfg_be[1] && cfg_wdata[15];
      end
   end

   assign cfg_flags = {en, 4'b0000, 11'(ENTRIES - 1)};

   // R11: the deassert pulse only follows a write that left the block enabled
   a_r11_intx_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      intx_clr |-> cfg_flags[15]);
endmodule

// File: tb/msix_vec_ctrl_test.sv
module msix_vec_ctrl_test;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0, reg_write = 1'b0;
   logic [1:0]  reg_size = 2'd2;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_be = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_flags;
   logic        intx_clr;
   logic        vuse_valid = 1'b0, vuse_unuse = 1'b0;
   logic [4:0]  vuse_idx = '0;
   logic        vuse_err;
   logic        irq_valid = 1'b0;
   logic [4:0]  irq_idx = '0;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rv;

   msix_vec_ctrl #(.ENTRIES(N), .CNT_W(4)) uut (.*);

   always #2 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   function automatic logic [31:0] lo_of(int v); return 32'hFEE0_0000 | (v << 4); endfunction
   function automatic logic [31:0] hi_of(int v); return 32'h11 * v; endfunction
   function automatic logic [31:0] dt_of(int v); return 32'h1000 + v; endfunction

   task automatic reg_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
      reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d; reg_size = sz;
      @(negedge clk);
      reg_valid = 0; reg_write = 0; reg_size = 2'd2;
   endtask

   task automatic reg_rd(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
      reg_valid = 1; reg_write = 0; reg_addr = a; reg_size = sz;
      @(negedge clk);
      reg_valid = 0; reg_size = 2'd2;
      d = reg_rdata;
   endtask

   task automatic use_cmd(input int v, input logic un);
      vuse_valid = 1; vuse_unuse = un; vuse_idx = 5'(v);
      @(negedge clk);
      vuse_valid = 0; vuse_unuse = 0;
   endtask

   task automatic fire(input int v);
      irq_valid = 1; irq_idx = 5'(v);
      @(negedge clk);
      irq_valid = 0;
   endtask

   task automatic expect_msg(input int v, input string req);
      int waited = 0;
      while (!msg_valid && waited < 12) begin
         @(negedge clk);
         waited++;
      end
      chk(req, {63'b0, msg_valid}, 64'd1);
      chk(req, msg_addr, {hi_of(v), lo_of(v)});
      chk(req, {32'b0, msg_data}, {32'b0, dt_of(v)});
      msg_ready = 1;
      @(negedge clk);
      msg_ready = 0;
      chk({req, " R5 drop after accept"}, {63'b0, msg_valid}, 64'd0);
   endtask

   task automatic expect_none(input string req);
      repeat (6) @(negedge clk);
      chk(req, {63'b0, msg_valid}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 msg_valid", {63'b0, msg_valid}, 64'd0);
      chk("R12 R10 flags", {48'b0, cfg_flags}, 64'h0007);
      chk("R12 intx", {63'b0, intx_clr}, 64'd0);
      rst_n = 1;
      @(negedge clk);
      reg_rd(12'h000, 2'd2, rv); chk("R12 table word", {32'b0, rv}, 64'd0);
      reg_rd(12'h800, 2'd2, rv); chk("R12 pba", {32'b0, rv}, 64'd0);

      // R1 sweep: write and read back every word of every entry
      for (int v = 0; v < N; v++) begin
         reg_wr(12'(v * 16 + 0), lo_of(v), 2'd2);
         reg_wr(12'(v * 16 + 4), hi_of(v), 2'd2);
         reg_wr(12'(v * 16 + 8), dt_of(v), 2'd2);
         reg_wr(12'(v * 16 + 12), 32'h0, 2'd2);
      end
      for (int v = 0; v < N; v++) begin
         reg_rd(12'(v * 16 + 0), 2'd2, rv); chk("R1 addr lo", {32'b0, rv}, {32'b0, lo_of(v)});
         reg_rd(12'(v * 16 + 4), 2'd2, rv); chk("R1 addr hi", {32'b0, rv}, {32'b0, hi_of(v)});
         reg_rd(12'(v * 16 + 8), 2'd2, rv); chk("R1 data", {32'b0, rv}, {32'b0, dt_of(v)});
         reg_rd(12'(v * 16 + 12), 2'd2, rv); chk("R1 ctrl", {32'b0, rv}, 64'd0);
      end

      // R2 narrow accesses and out-of-range entries
      reg_wr(12'h008, 32'hDEAD_BEEF, 2'd0);
      reg_wr(12'h008, 32'hDEAD_BEEF, 2'd1);
      reg_rd(12'h008, 2'd2, rv); chk("R2 narrow write discarded", {32'b0, rv}, {32'b0, dt_of(0)});
      reg_rd(12'h000, 2'd1, rv); chk("R2 half read zero", {32'b0, rv}, 64'd0);
      reg_rd(12'h000, 2'd0, rv); chk("R2 byte read zero", {32'b0, rv}, 64'd0);
      reg_wr(12'(N * 16 + 8), 32'h1234_5678, 2'd2);
      reg_rd(12'(N * 16 + 8), 2'd2, rv); chk("R2 beyond entries", {32'b0, rv}, 64'd0);

      // R3 drops: unused vector and out-of-range index
      fire(3);
      expect_none("R3 unused vector");
      fire(9);
      expect_none("R3 out-of-range");
      reg_rd(12'h800, 2'd2, rv); chk("R3 no pending", {32'b0, rv}, 64'd0);

      // R9 out-of-range use
      use_cmd(9, 1'b0);
      chk("R9 use_err pulse", {63'b0, vuse_err}, 64'd1);
      @(negedge clk);
      chk("R9 use_err clears", {63'b0, vuse_err}, 64'd0);

      // R4 each vector delivers
      for (int v = 0; v < N; v++) use_cmd(v, 1'b0);
      for (int v = 0; v < N; v++) begin
         fire(v);
         chk("R4 not before second edge", {63'b0, msg_valid}, 64'd0);
         @(negedge clk);
         chk("R4 valid at second edge", {63'b0, msg_valid}, 64'd1);
         expect_msg(v, "R4 message");
      end

      // R9 unuse semantics, no wrap at zero
      use_cmd(2, 1'b1);
      fire(2);
      expect_none("R9 unuse to zero drops");
      use_cmd(2, 1'b1);
      use_cmd(2, 1'b0);
      use_cmd(2, 1'b1);
      fire(2);
      expect_none("R9 unuse at zero no wrap");
      use_cmd(2, 1'b0);
      fire(2);
      expect_msg(2, "R9 reuse delivers");

      // R6 mask all, fire all
      for (int v = 0; v < N; v++) reg_wr(12'(v * 16 + 12), 32'h1, 2'd2);
      reg_rd(12'h00C, 2'd2, rv); chk("R6 ctrl readback", {32'b0, rv}, 64'd1);
      for (int v = 0; v < N; v++) fire(v);
      expect_none("R6 masked no message");
      reg_rd(12'h800, 2'd2, rv); chk("R6 pending all", {32'b0, rv}, 64'h00FF);

      // R13 pending array read-only
      reg_wr(12'h800, 32'h0, 2'd2);
      reg_rd(12'h800, 2'd2, rv); chk("R13 pba write ignored", {32'b0, rv}, 64'h00FF);

      // R7 masked write sends nothing
      reg_wr(12'(4 * 16 + 8), dt_of(4), 2'd2);
      expect_none("R7 still masked");

      // R7 unmask high to low, each releases one
      for (int v = N - 1; v >= 0; v--) begin
         reg_wr(12'(v * 16 + 12), 32'h0, 2'd2);
         expect_msg(v, "R7 replay");
         reg_rd(12'h800, 2'd2, rv);
         chk("R7 pending cleared", {32'b0, rv}, 64'((1 << v) - 1));
      end

      // R8 queued behind stalled port, ascending order
      fire(5);
      fire(2);
      fire(6);
      fire(1);
      expect_msg(5, "R8 first");
      expect_msg(1, "R8 ascending");
      expect_msg(2, "R8 ascending");
      expect_msg(6, "R8 ascending");

      // R10 R11 config flags
      cfg_wr = 1; cfg_be = 2'b01; cfg_wdata = 16'h8000;
      @(negedge clk); cfg_wr = 0;
      chk("R10 low lane no enable", {48'b0, cfg_flags}, 64'h0007);
      chk("R11 no pulse", {63'b0, intx_clr}, 64'd0);
      cfg_wr = 1; cfg_be = 2'b11; cfg_wdata = 16'hFFFF;
      @(negedge clk); cfg_wr = 0;
      chk("R10 enable set, size fixed", {48'b0, cfg_flags}, 64'h8007);
      chk("R11 pulse", {63'b0, intx_clr}, 64'd1);
      @(negedge clk);
      chk("R11 pulse ends", {63'b0, intx_clr}, 64'd0);
      cfg_wr = 1; cfg_be = 2'b10; cfg_wdata = 16'h0000;
      @(negedge clk); cfg_wr = 0;
      chk("R10 enable cleared", {48'b0, cfg_flags}, 64'h0007);
      chk("R11 no pulse on clear", {63'b0, intx_clr}, 64'd0);
      cfg_wr = 1; cfg_be = 2'b10; cfg_wdata = 16'h8000;
      @(negedge clk); cfg_wr = 0;

      // R12 reset mid-run
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R12 enable cleared", {48'b0, cfg_flags}, 64'h0007);
      reg_rd(12'h008, 2'd2, rv); chk("R12 table cleared", {32'b0, rv}, 64'd0);
      fire(0);
      expect_none("R12 use counters cleared");
      reg_rd(12'h800, 2'd2, rv); chk("R12 pending cleared", {32'b0, rv}, 64'd0);

      summary();
   end
endmodule